// File: doc/BRIEF.md
# Bit-Serial SIMD Processor-in-Memory Array

This block places one single-bit processing element at the sense-amplifier edge of every column of a small memory array. A single externally issued instruction drives all elements at once. The instruction names one row. Every element reads its column's bit of that row. It combines the bit with its two local one-bit registers X and Y through an 8-entry truth table carried in the instruction. The result is then written to X, to Y, to the element's write-enable flag, or back into the same memory row. Wide arithmetic is built by the controlling host as a sequence of such single-bit steps.

A global tie line forms the AND of every element's result, which makes global tests such as "all zero" possible. An instruction can also broadcast that AND into a register of every element. A plain row port lets the host load and inspect the memory between instructions. Each instruction occupies a fixed three-clock read, operate and write sequence. The instruction port shows ready only between sequences.

Top module: `pim_array`

## Requirements
- R1: After reset, instr_ready is 1 and tie_out is 1. Every element has X=0 and Y=0, and its write-enable flag is 1.
- R2: An instruction is accepted on a clock edge where instr_valid and instr_ready are both 1. instr_ready is then 0 for exactly three cycles and returns to 1 in the fourth. All results of the instruction are visible when instr_ready returns.
- R3: Each element's result is instr_func[{X,Y,M}]: X is index bit 2, Y is index bit 1, and M (the element's bit of row instr_row) is index bit 0. For example, 8'hAA passes M, 8'hCC passes Y, 8'hF0 passes X, 8'h96 gives the three-input XOR and 8'hE8 gives the majority.
- R4: instr_dest selects the target of the result. The codes are 0 = register X, 1 = register Y, 2 = memory row instr_row, and 3 = the element's write-enable flag. Targets that are not selected keep their value.
- R5: A memory write-back changes only the columns whose write-enable flag is 1. All other columns of the row keep their value.
- R6: When an instruction completes, tie_out becomes the AND of all element results if instr_tie_en was 1, and 1 if it was 0. tie_out holds that value until the next instruction completes.
- R7: With instr_tie_en=1 and instr_bcast=1, a register target (X, Y or write-enable) in every element loads the tie value in place of its local result. A memory target always stores the local result.
- R8: A host write (host_we=1 with instr_ready=1) stores host_wdata into row host_waddr. A host write while instr_ready is 0 is ignored.
- R9: host_rdata shows row host_raddr one clock after the address is presented, and includes all writes completed before that edge.
- R10: The instruction fields are captured at acceptance. instr_valid and field changes while busy neither restart nor alter the running instruction, and they start no second instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction offered |
| instr_ready | output | 1 | Array idle, instruction may be accepted |
| instr_row | input | ROW_W | Row operated on |
| instr_func | input | 8 | Truth table indexed by {X,Y,M} |
| instr_dest | input | 2 | Result target: 0 X, 1 Y, 2 memory, 3 write-enable |
| instr_tie_en | input | 1 | Drive the global AND onto the tie line |
| instr_bcast | input | 1 | Register targets load the tie value |
| tie_out | output | 1 | Tie value of the last completed instruction |
| host_we | input | 1 | Host row write |
| host_waddr | input | ROW_W | Host write row |
| host_wdata | input | NUM_PE | Host write data, bit i to column i |
| host_raddr | input | ROW_W | Host read row |
| host_rdata | output | NUM_PE | Registered row read data |

## Verification
An instruction accepted at one edge updates its registers, its memory row and tie_out at the third edge after that one. The bench therefore drives on falling edges and checks that instr_ready is low at the three falling edges that follow acceptance. It reads the results only at the fourth falling edge, when instr_ready has returned. Register contents are brought out by copying X or Y into a memory row with a pass-through table. Every row is read back through host_rdata one falling edge after its address is set, because the read port is registered.

// File: rtl/pim_pkg.sv
package pim_pkg;

    localparam int FUNC_W = 8;

    typedef enum logic [1:0] {
        DST_X   = 2'd0,
        DST_Y   = 2'd1,
        DST_MEM = 2'd2,
        DST_WE  = 2'd3
    } dest_t;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_READ  = 2'd1,
        PH_OPER  = 2'd2,
        PH_WRITE = 2'd3
    } phase_t;

    typedef struct packed {
        logic [FUNC_W-1:0] func;
        dest_t             dest;
        logic              tie_en;
        logic              bcast;
    } op_t;

    function automatic logic lut_pick(input logic [FUNC_W-1:0] tbl,
                                      input logic x, input logic y,
                                      input logic m);
        logic [2:0] idx;
        idx = {x, y, m};
        return tbl[idx];
    endfunction

endpackage

// File: rtl/pim_seq.sv
module pim_seq
    import pim_pkg::*;
#(
    parameter int ROW_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             instr_valid,
    input  logic [ROW_W-1:0] row_in,
    input  op_t              op_in,
    output logic             instr_ready,
    output phase_t           phase,
    output logic [ROW_W-1:0] row_q,
    output op_t              op_q
);

    logic accept;

    assign instr_ready = (phase == PH_IDLE);
    assign accept      = instr_valid && instr_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            row_q <= '0;
            op_q  <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (accept) begin
                        phase <= PH_READ;
                        row_q <= row_in;
                        op_q  <= op_in;
                    end
                end
                PH_READ:  phase <= PH_OPER;
                PH_OPER:  phase <= PH_WRITE;
                PH_WRITE: phase <= PH_IDLE;
                default:  phase <= PH_IDLE;
            endcase
        end
    end

    assert_busy_window_R2: assert property (@(posedge clk) disable iff (rst)
        accept |=> !instr_ready ##1 !instr_ready ##1 !instr_ready ##1 instr_ready);

    assert_no_restart_R10: assert property (@(posedge clk) disable iff (rst)
        (!instr_ready && instr_valid) |=> $stable(row_q) && $stable(op_q));

endmodule

// File: rtl/pim_mem.sv
module pim_mem #(
    parameter int NUM_PE   = 64,
    parameter int NUM_ROWS = 16,
    parameter int ROW_W    = 4
) (
    input  logic              clk,
    input  logic              host_we,
    input  logic [ROW_W-1:0]  host_waddr,
    input  logic [NUM_PE-1:0] host_wdata,
    input  logic [ROW_W-1:0]  host_raddr,
    output logic [NUM_PE-1:0] host_rdata,
    input  logic [ROW_W-1:0]  pe_row,
    output logic [NUM_PE-1:0] pe_sense,
    input  logic              pe_we,
    input  logic [NUM_PE-1:0] pe_mask,
    input  logic [NUM_PE-1:0] pe_wdata
);

    logic [NUM_PE-1:0] cells [NUM_ROWS];

    assign pe_sense = cells[pe_row];

    always_ff @(posedge clk) begin
        if (pe_we) begin
            cells[pe_row] <= (cells[pe_row] & ~pe_mask) | (pe_wdata & pe_mask);
        end else if (host_we) begin
            cells[host_waddr] <= host_wdata;
        end
        host_rdata <= cells[host_raddr];
    end

endmodule

// File: rtl/pim_pe.sv
module pim_pe
    import pim_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  phase_t            phase,
    input  op_t               op,
    input  logic              m_in,
    input  logic              tie_val,
    output logic              res_q,
    output logic              x_q,
    output logic              y_q,
    output logic              we_q
);

    logic m_q;
    logic load_val;

    assign load_val = (op.bcast && op.tie_en) ? tie_val : res_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            m_q   <= 1'b0;
            res_q <= 1'b0;
            x_q   <= 1'b0;
            y_q   <= 1'b0;
            we_q  <= 1'b1;
        end else begin
            unique case (phase)
                PH_READ: m_q   <= m_in;
                PH_OPER: res_q <= lut_pick(op.func, x_q, y_q, m_q);
                PH_WRITE: begin
                    unique case (op.dest)
                        DST_X:   x_q  <= load_val;
                        DST_Y:   y_q  <= load_val;
                        DST_WE:  we_q <= load_val;
                        default: ;
                    endcase
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/pim_array.sv
module pim_array
    import pim_pkg::*;
#(
    parameter int NUM_PE   = 64,
    parameter int NUM_ROWS = 16,
    localparam int ROW_W   = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              instr_valid,
    output logic              instr_ready,
    input  logic [ROW_W-1:0]  instr_row,
    input  logic [7:0]        instr_func,
    input  logic [1:0]        instr_dest,
    input  logic              instr_tie_en,
    input  logic              instr_bcast,
    output logic              tie_out,
    input  logic              host_we,
    input  logic [ROW_W-1:0]  host_waddr,
    input  logic [NUM_PE-1:0] host_wdata,
    input  logic [ROW_W-1:0]  host_raddr,
    output logic [NUM_PE-1:0] host_rdata
);

    op_t               op_in;
    op_t               op_q;
    phase_t            phase;
    logic [ROW_W-1:0]  row_q;
    logic [NUM_PE-1:0] sense;
    logic [NUM_PE-1:0] res_vec;
    logic [NUM_PE-1:0] x_vec;
    logic [NUM_PE-1:0] y_vec;
    logic [NUM_PE-1:0] we_vec;
    logic              tie_val;
    logic              mem_wr;
    logic              host_ok;

    assign op_in = '{func: instr_func, dest: dest_t'(instr_dest),
                     tie_en: instr_tie_en, bcast: instr_bcast};

    pim_seq #(.ROW_W(ROW_W)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .instr_valid (instr_valid),
        .row_in      (instr_row),
        .op_in       (op_in),
        .instr_ready (instr_ready),
        .phase       (phase),
        .row_q       (row_q),
        .op_q        (op_q)
    );

    assign tie_val = op_q.tie_en ? (&res_vec) : 1'b1;
    assign mem_wr  = (phase == PH_WRITE) && (op_q.dest == DST_MEM);
    assign host_ok = host_we && instr_ready;

    pim_mem #(.NUM_PE(NUM_PE), .NUM_ROWS(NUM_ROWS), .ROW_W(ROW_W)) u_mem (
        .clk        (clk),
        .host_we    (host_ok),
        .host_waddr (host_waddr),
        .host_wdata (host_wdata),
        .host_raddr (host_raddr),
        .host_rdata (host_rdata),
        .pe_row     (row_q),
        .pe_sense   (sense),
        .pe_we      (mem_wr),
        .pe_mask    (we_vec),
        .pe_wdata   (res_vec)
    );

    for (genvar i = 0; i < NUM_PE; i++) begin : g_pe
        pim_pe u_pe (
            .clk     (clk),
            .rst     (rst),
            .phase   (phase),
            .op      (op_q),
            .m_in    (sense[i]),
            .tie_val (tie_val),
            .res_q   (res_vec[i]),
            .x_q     (x_vec[i]),
            .y_q     (y_vec[i]),
            .we_q    (we_vec[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tie_out <= 1'b1;
        end else if (phase == PH_WRITE) begin
            tie_out <= tie_val;
        end
    end

    assert_tie_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_WRITE) |=> $stable(tie_out));

    assert_bcast_uniform_R7: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_WRITE && op_q.bcast && op_q.tie_en && op_q.dest == DST_X)
        |=> ((&x_vec) || !(|x_vec)));

    assert_host_blocked_R8: assert property (@(posedge clk) disable iff (rst)
        (host_we && !instr_ready && phase != PH_WRITE && host_waddr == row_q)
        |=> $stable(sense));

endmodule

// File: tb/pim_array_test.sv
module pim_array_test;
    localparam int N = 64;
    localparam int RW = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic          instr_valid;
    logic          instr_ready;
    logic [RW-1:0] instr_row;
    logic [7:0]    instr_func;
    logic [1:0]    instr_dest;
    logic          instr_tie_en;
    logic          instr_bcast;
    logic          tie_out;
    logic          host_we;
    logic [RW-1:0] host_waddr;
    logic [N-1:0]  host_wdata;
    logic [RW-1:0] host_raddr;
    logic [N-1:0]  host_rdata;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    pim_array #(.NUM_PE(N), .NUM_ROWS(16)) uut (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_ready(instr_ready),
        .instr_row(instr_row), .instr_func(instr_func), .instr_dest(instr_dest),
        .instr_tie_en(instr_tie_en), .instr_bcast(instr_bcast), .tie_out(tie_out),
        .host_we(host_we), .host_waddr(host_waddr), .host_wdata(host_wdata),
        .host_raddr(host_raddr), .host_rdata(host_rdata)
    );

    localparam logic [N-1:0] PA = 64'hF0F0_1234_5678_9ABC;
    localparam logic [N-1:0] PB = 64'h0FF0_CAFE_0123_4567;
    localparam logic [N-1:0] PC = 64'h3C3C_A5A5_FFFF_0000;
    localparam logic [N-1:0] PD = 64'h8001_7E7E_1357_2468;
    localparam logic [N-1:0] PM = 64'h00FF_0F0F_AAAA_5555;
    localparam logic [N-1:0] PE = 64'h1111_2222_4444_8888;
    localparam logic [N-1:0] ONES = {N{1'b1}};

    task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hwrite(input logic [RW-1:0] r, input logic [N-1:0] d);
        @(negedge clk);
        host_we = 1'b1; host_waddr = r; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic hread(input logic [RW-1:0] r, output logic [N-1:0] d);
        @(negedge clk);
        host_raddr = r;
        @(negedge clk);
        d = host_rdata;
    endtask

    // R2: ready low for three falling edges after acceptance, high at the fourth
    task automatic issue(input logic [RW-1:0] r, input logic [7:0] f, input logic [1:0] dst,
                         input logic te, input logic bc);
        @(negedge clk);
        instr_valid = 1'b1; instr_row = r; instr_func = f; instr_dest = dst;
        instr_tie_en = te; instr_bcast = bc;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            instr_valid = 1'b0;
            chk("R2 busy", {63'd0, instr_ready}, 64'd0);
        end
        @(negedge clk);
        chk("R2 ready", {63'd0, instr_ready}, 64'd1);
    endtask

    task automatic t_reset();
        logic [N-1:0] d;
        chk("R1 ready", {63'd0, instr_ready}, 64'd1);
        chk("R1 tie", {63'd0, tie_out}, 64'd1);
        hwrite(4'd9, PA);
        issue(4'd9, 8'hF0, 2'd2, 1'b0, 1'b0);
        hread(4'd9, d);
        chk("R1 X zero", d, '0);
        hwrite(4'd9, PB);
        issue(4'd9, 8'hCC, 2'd2, 1'b0, 1'b0);
        hread(4'd9, d);
        chk("R1 Y zero", d, '0);
    endtask

    task automatic t_host();
        logic [N-1:0] d;
        hwrite(4'd0, PA);
        hwrite(4'd1, PB);
        hwrite(4'd2, PC);
        hwrite(4'd3, PD);
        hread(4'd0, d);
        chk("R9 row0", d, PA);
        hread(4'd3, d);
        chk("R9 row3", d, PD);
    endtask

    task automatic t_func();
        logic [N-1:0] d;
        issue(4'd0, 8'hAA, 2'd0, 1'b0, 1'b0);
        issue(4'd1, 8'hAA, 2'd1, 1'b0, 1'b0);
        issue(4'd2, 8'h96, 2'd2, 1'b0, 1'b0);
        hread(4'd2, d);
        chk("R3 xor3", d, PA ^ PB ^ PC);
        issue(4'd3, 8'hE8, 2'd2, 1'b0, 1'b0);
        hread(4'd3, d);
        chk("R3 majority", d, (PA & PB) | (PA & PD) | (PB & PD));
        hread(4'd0, d);
        chk("R4 row0 untouched by X target", d, PA);
    endtask

    task automatic t_dest();
        logic [N-1:0] d;
        issue(4'd5, 8'hF0, 2'd1, 1'b0, 1'b0);
        hwrite(4'd6, PE);
        issue(4'd6, 8'hCC, 2'd2, 1'b0, 1'b0);
        hread(4'd6, d);
        chk("R4 Y holds X", d, PA);
        hwrite(4'd6, PE);
        issue(4'd6, 8'hF0, 2'd2, 1'b0, 1'b0);
        hread(4'd6, d);
        chk("R4 X kept", d, PA);
    endtask

    task automatic t_mask();
        logic [N-1:0] d;
        hwrite(4'd4, PM);
        hwrite(4'd5, PE);
        issue(4'd4, 8'hAA, 2'd3, 1'b0, 1'b0);
        issue(4'd5, 8'hFF, 2'd2, 1'b0, 1'b0);
        hread(4'd5, d);
        chk("R5 masked write", d, PE | PM);
        hwrite(4'd5, PE);
        issue(4'd5, 8'h00, 2'd2, 1'b0, 1'b0);
        hread(4'd5, d);
        chk("R5 masked clear", d, PE & ~PM);
        issue(4'd5, 8'hFF, 2'd3, 1'b0, 1'b0);
    endtask

    task automatic t_tie();
        logic [N-1:0] z;
        hwrite(4'd7, ONES);
        hwrite(4'd8, ONES ^ (64'd1 << 37));
        issue(4'd7, 8'hAA, 2'd0, 1'b1, 1'b0);
        chk("R6 all ones", {63'd0, tie_out}, 64'd1);
        issue(4'd8, 8'hAA, 2'd0, 1'b1, 1'b0);
        chk("R6 one zero", {63'd0, tie_out}, 64'd0);
        hread(4'd7, z);
        chk("R6 held", {63'd0, tie_out}, 64'd0);
        issue(4'd8, 8'hAA, 2'd0, 1'b0, 1'b0);
        chk("R6 disabled", {63'd0, tie_out}, 64'd1);
    endtask

    task automatic t_bcast();
        logic [N-1:0] d;
        issue(4'd7, 8'hAA, 2'd0, 1'b1, 1'b1);
        hwrite(4'd10, PC);
        issue(4'd10, 8'hF0, 2'd2, 1'b0, 1'b0);
        hread(4'd10, d);
        chk("R7 bcast one", d, ONES);
        issue(4'd8, 8'hAA, 2'd0, 1'b1, 1'b1);
        hwrite(4'd10, PC);
        issue(4'd10, 8'hF0, 2'd2, 1'b0, 1'b0);
        hread(4'd10, d);
        chk("R7 bcast zero", d, '0);
        hwrite(4'd11, PD);
        issue(4'd11, 8'hAA, 2'd2, 1'b1, 1'b1);
        hread(4'd11, d);
        chk("R7 memory keeps local", d, PD);
    endtask

    // R10 and R8: valid and host writes during busy are ignored
    task automatic t_busy();
        logic [N-1:0] d;
        hwrite(4'd12, PA);
        hwrite(4'd13, PB);
        @(negedge clk);
        instr_valid = 1'b1; instr_row = 4'd12; instr_func = 8'h55;
        instr_dest = 2'd2; instr_tie_en = 1'b0; instr_bcast = 1'b0;
        @(negedge clk);
        instr_row = 4'd13; instr_func = 8'h00;
        host_we = 1'b1; host_waddr = 4'd13; host_wdata = PC;
        chk("R10 busy1", {63'd0, instr_ready}, 64'd0);
        @(negedge clk);
        chk("R10 busy2", {63'd0, instr_ready}, 64'd0);
        @(negedge clk);
        chk("R10 busy3", {63'd0, instr_ready}, 64'd0);
        instr_valid = 1'b0; host_we = 1'b0;
        @(negedge clk);
        chk("R10 ready", {63'd0, instr_ready}, 64'd1);
        hread(4'd12, d);
        chk("R10 first op kept", d, ~PA);
        hread(4'd13, d);
        chk("R8 busy write ignored", d, PB);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; instr_valid = 1'b0; instr_row = '0; instr_func = '0;
        instr_dest = '0; instr_tie_en = 1'b0; instr_bcast = 1'b0;
        host_we = 1'b0; host_waddr = '0; host_wdata = '0; host_raddr = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_host();
        t_func();
        t_dest();
        t_mask();
        t_tie();
        t_bcast();
        t_busy();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule